// File: doc/BRIEF.md
# Two-Wire Serial Slave with 512-Byte Store

This block is a two-wire (I2C) bus slave in front of a 512 x 8 byte store held in an internal register array. It runs entirely in the system clock domain. It oversamples the bus clock and data lines, finds START and STOP conditions, and shifts in the address byte. It answers when the address byte carries its fixed device code and matches its two strap pins. Four such slaves can therefore share one bus.

A write transfer carries a word address and then one data byte. The byte is committed only when the master closes the transfer with a STOP. That STOP also opens a busy window that stands in for a nonvolatile programming cycle. While the window is open the slave is deaf to the bus: it drives nothing and acknowledges nothing, not even its own address.

A read transfer returns the byte at the internal pointer. The pointer then advances, and the slave keeps sending bytes while the master acknowledges. One bit of the address byte is not a device-select bit: it is the top bit of the 9-bit byte address. This lets one slave span all 512 locations with an 8-bit word address.

Top module: `i2c_mem_slave`

## Requirements
- R1: After reset, the slave releases SDA (sda_oe_o = 0), busy_o = 0, and every location of the store reads back as 0x00.
- R2: The slave acknowledges an address byte (pulls SDA low during the ninth clock) only when the byte's bits [7:4] equal 4'b1010 and bits [3:2] equal strap_i[1:0]. Bit 0 is the direction (1 = read, 0 = write). For any other byte it drives nothing for the rest of the transfer.
- R3: In a write transfer the slave acknowledges the word address byte and the data byte. On the following STOP, the data byte is stored at the 9-bit address {address-byte bit 1, word address}.
- R4: A repeated START after the data byte abandons the write, so nothing is stored and busy_o stays low. A further byte sent after the data byte is not acknowledged, and a STOP after it still commits the single data byte.
- R5: The STOP that commits a write raises busy_o for exactly BUSY_CYCLES clocks. For that whole window the slave never drives SDA and does not acknowledge its own address.
- R6: A read sends the byte at {address-byte bit 1, pointer[7:0]}, most significant bit first. The pointer then advances over all 9 bits with wrap-around (0x1FF goes to 0x000), and the next byte follows for as long as the master acknowledges.
- R7: When the master answers a read byte with a no-acknowledge, the slave releases SDA and drives nothing until the next START. A START always makes the slave release SDA.
- R8: A word address received in a write transfer sets the pointer, so a repeated START followed by a read returns that location. A committed write leaves the pointer at the written address plus one.
- R9: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; bus lines are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| strap_i | input | 2 | Board strap bits compared with address-byte bits [3:2] |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| busy_o | output | 1 | High during the post-write programming window |

## Verification
A wrong sequencer state shows at the ports within one byte time. It appears as an acknowledge missing or present on the ninth clock, or as SDA held low after a no-acknowledge. A slip in the bit counter or the shift register puts a wrong byte on the bus on the next read. A pointer or block-bit fault shows only when a later read lands on the wrong location, so each location is read back after it is written. Timer faults show as a busy pulse whose length differs from BUSY_CYCLES, or as an acknowledge given to the deaf probe issued inside the window.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = BYTE_W + 1;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK, ST_WSTOP, ST_TX, ST_RACK, ST_BUSY
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_DEV, PH_WADDR, PH_DATA
  } byte_phase_e;
endpackage

// File: rtl/i2cm_line_sync.sv
module i2cm_line_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl_o,
  output logic sda_lvl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 2'b11;
      sync_q <= 2'b11;
      prev_q <= 2'b11;
    end else begin
      meta_q <= {scl_i, sda_i};
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign scl_lvl_o  = sync_q[1];
  assign sda_lvl_o  = sync_q[0];
  assign scl_rise_o = sync_q[1] & ~prev_q[1];
  assign scl_fall_o = ~sync_q[1] & prev_q[1];
  assign start_o    = sync_q[1] & prev_q[1] & prev_q[0] & ~sync_q[0];
  assign stop_o     = sync_q[1] & prev_q[1] & ~prev_q[0] & sync_q[0];
endmodule

// File: rtl/i2cm_busy_timer.sv
module i2cm_busy_timer #(
  parameter int BUSY_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic busy_o
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)            cnt_d = CW'(BUSY_CYCLES);
    else if (cnt_q != '0)  cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);

  assert_busy_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> busy_o);
  assert_busy_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !load_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/i2cm_mem_array.sv
module i2cm_mem_array #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  assert_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave
  import i2cm_pkg::*;
#(
  parameter int BUSY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] strap_i,
  output logic       sda_oe_o,
  output logic       busy_o
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start, stop;

  i2cm_line_sync u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl_o(scl_lvl), .sda_lvl_o(sda_lvl), .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
  );

  seq_state_e        st_q, st_d;
  byte_phase_e       ph_q, ph_d;
  logic [3:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] sh_q, sh_d, tx_q, tx_d, wd_q, wd_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, rd_addr;
  logic              blk_q, blk_d, rw_q, rw_d, oe_q, oe_d, mack_q, mack_d;
  logic              mem_we, tmr_load, tmr_busy, dev_match;
  logic [BYTE_W-1:0] rd_data;

  i2cm_mem_array #(.DEPTH(DEPTH), .DW(BYTE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we_i(mem_we), .waddr_i(ptr_q),
    .wdata_i(wd_q), .raddr_i(rd_addr), .rdata_o(rd_data)
  );

  i2cm_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .busy_o(tmr_busy)
  );

  assign dev_match = (sh_q[7:4] == DEV_CODE) && (sh_q[3:2] == strap_i);
  assign rd_addr   = (st_q == ST_ACK) ? {blk_q, ptr_q[BYTE_W-1:0]} : ptr_q;

  always_comb begin
    st_d = st_q;  ph_d = ph_q;  bit_d = bit_q;  sh_d = sh_q;  tx_d = tx_q;
    wd_d = wd_q;  ptr_d = ptr_q;  blk_d = blk_q;  rw_d = rw_q;  oe_d = oe_q;
    mack_d = mack_q;  mem_we = 1'b0;  tmr_load = 1'b0;
    if (st_q != ST_BUSY && start) begin
      st_d = ST_RECV;  ph_d = PH_DEV;  bit_d = '0;  oe_d = 1'b0;
    end else if (st_q != ST_BUSY && stop) begin
      oe_d = 1'b0;
      if (st_q == ST_WSTOP) begin
        mem_we = 1'b1;  tmr_load = 1'b1;  ptr_d = ptr_q + ADDR_W'(1);
        st_d = ST_BUSY;
      end else begin
        st_d = ST_IDLE;
      end
    end else begin
      case (st_q)
        ST_RECV: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_lvl};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            oe_d = 1'b1;  st_d = ST_ACK;
            case (ph_q)
              PH_DEV: begin
                blk_d = sh_q[1];  rw_d = sh_q[0];
                if (!dev_match) begin oe_d = 1'b0; st_d = ST_IDLE; end
              end
              PH_WADDR: ptr_d = {blk_q, sh_q};
              default:  wd_d  = sh_q;
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_d = '0;  oe_d = 1'b0;
            case (ph_q)
              PH_DEV: begin
                if (rw_q) begin
                  tx_d = rd_data;  ptr_d = rd_addr + ADDR_W'(1);
                  oe_d = ~rd_data[BYTE_W-1];  st_d = ST_TX;
                end else begin
                  ph_d = PH_WADDR;  st_d = ST_RECV;
                end
              end
              PH_WADDR: begin ph_d = PH_DATA; st_d = ST_RECV; end
              default:  st_d = ST_WSTOP;
            endcase
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d = 1'b0;  st_d = ST_RACK;
            end else begin
              tx_d = tx_q << 1;  oe_d = ~tx_q[BYTE_W-2];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_lvl;  bit_d = 4'd9;
          end else if (scl_fall && bit_q == 4'd9) begin
            if (mack_q) begin
              tx_d = rd_data;  ptr_d = ptr_q + ADDR_W'(1);
              oe_d = ~rd_data[BYTE_W-1];  bit_d = '0;  st_d = ST_TX;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        ST_BUSY: if (!tmr_busy) st_d = ST_IDLE;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  ph_q <= PH_DEV;  bit_q <= '0;  sh_q <= '0;  tx_q <= '0;
      wd_q <= '0;  ptr_q <= '0;  blk_q <= 1'b0;  rw_q <= 1'b0;  oe_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q <= st_d;  ph_q <= ph_d;  bit_q <= bit_d;  sh_q <= sh_d;  tx_q <= tx_d;
      wd_q <= wd_d;  ptr_q <= ptr_d;  blk_q <= blk_d;  rw_q <= rw_d;  oe_q <= oe_d;
      mack_q <= mack_d;
    end
  end

  assign sda_oe_o = oe_q;
  assign busy_o   = tmr_busy;

  assert_quiet_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !sda_oe_o);
  assert_sda_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_lvl) || $past(start) || $past(stop));
  assert_release_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_o && st_q != ST_BUSY) |=> !sda_oe_o);
  assert_busy_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (st_q == ST_BUSY));
endmodule

// File: tb/i2c_mem_slave_bench.sv
module i2c_mem_slave_bench;
  localparam int BUSY = 400;
  localparam int QTR  = 8;
  localparam logic [1:0] STRAP = 2'b10;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy, sda_line;
  int checks = 0, errors = 0, r9_viol = 0, run_len = 0, last_run = 0;
  logic [7:0] exp_mem [512];
  logic [8:0] ptr_model = '0;
  logic scl_prev = 1'b1, oe_prev = 1'b0;

  always #4 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave #(.BUSY_CYCLES(BUSY)) u_i2c_mem_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .strap_i(STRAP), .sda_oe_o(sda_oe), .busy_o(busy)
  );

  always @(posedge clk) begin
    if (rst_n && scl_m && scl_prev && sda_oe != oe_prev) r9_viol++;
    scl_prev <= scl_m;
    oe_prev  <= sda_oe;
    if (busy) run_len++;
    else if (run_len != 0) begin last_run = run_len; run_len = 0; end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic qd();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); sda_m = 1'b0; qd(); scl_m = 1'b0; qd();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qd(); scl_m = 1'b1; qd(); sda_m = 1'b1; qd();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qd(); scl_m = 1'b1; qd(); qd(); scl_m = 1'b0; qd();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; qd(); scl_m = 1'b1; qd(); ack = ~sda_line; qd(); scl_m = 1'b0; qd();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      qd(); scl_m = 1'b1; qd(); b = {b[6:0], sda_line}; qd(); scl_m = 1'b0; qd();
    end
    send_bit(~mack);
    sda_m = 1'b1;
  endtask

  function automatic logic [7:0] dev_byte(input logic blk, input logic rd);
    return {4'b1010, STRAP, blk, rd};
  endfunction

  task automatic write_txn(input logic [8:0] a, input logic [7:0] d);
    logic ack;
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), ack); chk(ack, "R3", "write addr-byte ack", ack, 1);
    send_byte(a[7:0], ack);               chk(ack, "R3", "word address ack", ack, 1);
    send_byte(d, ack);                    chk(ack, "R3", "data ack", ack, 1);
    bus_stop();
    exp_mem[a] = d;
    ptr_model  = a + 9'd1;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic read_seq(input logic [8:0] a, input int n, input string req);
    logic ack;
    logic [7:0] got;
    bus_start();
    send_byte(dev_byte(a[8], 1'b0), ack); chk(ack, "R8", "dummy write ack", ack, 1);
    send_byte(a[7:0], ack);               chk(ack, "R8", "dummy word ack", ack, 1);
    bus_start();
    send_byte(dev_byte(a[8], 1'b1), ack); chk(ack, "R6", "read addr-byte ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, got);
      chk(got == exp_mem[9'(a + 9'(k))], req, "read data", got, exp_mem[9'(a + 9'(k))]);
    end
    repeat (3 * QTR) @(negedge clk);
    chk(sda_oe == 1'b0, "R7", "released after NACK", sda_oe, 0);
    bus_stop();
    ptr_model = a + 9'(n);
  endtask

  function automatic logic [8:0] addr_of(input int i);
    case (i)
      0: return 9'h000;
      1: return 9'h0FF;
      2: return 9'h100;
      3: return 9'h1FF;
      default: return 9'((i * 97 + 13) % 512);
    endcase
  endfunction

  initial begin
    logic ack;
    logic [7:0] got;
    logic [8:0] ra;
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1", "reset sda_oe", sda_oe, 0);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);

    // R2: sweep device code and strap field of the address byte
    for (int code = 0; code < 16; code++) begin
      for (int st = 0; st < 4; st++) begin
        bus_start();
        send_byte({4'(code), 2'(st), 1'(code[0]), 1'b0}, ack);
        chk(ack == (code == 10 && st == int'(STRAP)), "R2", "address match ack", ack,
            int'(code == 10 && st == int'(STRAP)));
        bus_stop();
      end
    end
    chk(busy == 1'b0, "R2", "no commit from address-only transfers", busy, 0);

    // R1: store is clear after reset, read across the block boundary
    read_seq(9'h0FE, 4, "R1");

    // R3/R5/R6: writes at boundary and scattered addresses
    for (int i = 0; i < 8; i++) begin
      write_txn(addr_of(i), 8'((addr_of(i) ^ (addr_of(i) >> 1)) * 5 + i));
      repeat (8) @(negedge clk);
      chk(busy == 1'b1, "R5", "busy after commit", busy, 1);
      wait_idle();
      chk(last_run == BUSY, "R5", "busy length", last_run, BUSY);
    end

    // R8: current-address read after a write
    ra = {ptr_model[8], ptr_model[7:0]};
    bus_start();
    send_byte(dev_byte(ptr_model[8], 1'b1), ack);
    chk(ack, "R8", "current read ack", ack, 1);
    recv_byte(1'b0, got);
    chk(got == exp_mem[ra], "R8", "current-address byte", got, exp_mem[ra]);
    bus_stop();

    // R6: sequential read wrapping from 0x1FF to 0x000
    read_seq(9'h1FF, 3, "R6");
    for (int i = 0; i < 8; i++) read_seq(addr_of(i), 1, "R3");

    // R5: deaf during the busy window
    write_txn(9'h033, 8'hC3);
    repeat (8) @(negedge clk);
    chk(busy == 1'b1, "R5", "busy at probe", busy, 1);
    bus_start();
    send_byte(dev_byte(1'b0, 1'b1), ack);
    chk(ack == 1'b0, "R5", "no ack while busy", ack, 0);
    bus_stop();
    wait_idle();
    chk(last_run == BUSY, "R5", "busy length with traffic", last_run, BUSY);
    read_seq(9'h033, 1, "R3");

    // R4: repeated START after data abandons the write
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack);
    send_byte(8'h44, ack);
    send_byte(8'h99, ack);
    bus_start();
    bus_stop();
    repeat (16) @(negedge clk);
    chk(busy == 1'b0, "R4", "no busy after abandoned write", busy, 0);
    read_seq(9'h044, 1, "R4");

    // R4: extra byte after data is not acknowledged; STOP still commits
    bus_start();
    send_byte(dev_byte(1'b0, 1'b0), ack);
    send_byte(8'h45, ack);
    send_byte(8'h5A, ack);
    send_byte(8'h11, ack);
    chk(ack == 1'b0, "R4", "extra byte nack", ack, 0);
    bus_stop();
    exp_mem[9'h045] = 8'h5A;
    wait_idle();
    read_seq(9'h045, 1, "R4");

    chk(r9_viol == 0, "R9", "SDA drive changes while SCL high", r9_viol, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule